// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block keeps track of which pages of a small packet buffer pool are in use, one bit per page, each page standing for a 2048-byte slot of buffer memory held elsewhere. Two clients ask it for pages. The host issues one-byte commands whose top three bits select an operation: allocate for transmit, reset the pool, or release the page named by a separate packet-number input. The receive path asks for pages and gives them back through its own request and release inputs. Every allocation takes the lowest-numbered free page.

A transmit allocation that finds the pool full reports the failure code 0x80 and stays pending. The next release of any page retries it in the same cycle, with no further host action. A successful transmit allocation sets an allocation-done flag, and each new transmit allocate command clears that flag first. A free-page count is always available for status.

Top module: `page_allocator`

## Requirements
- R1: After reset no page is in use, the free count equals NUM_PAGES, the transmit result reads 0x00, the allocation-done flag is low and no receive response is valid.
- R2: A host command is decoded from bits [7:5] of the command byte alone: 1 allocates for transmit, 2 resets the pool, 5 releases the page given on the packet-number input. All other codes have no effect, and bits [4:0] are ignored.
- R3: Every allocation, from either client, takes the lowest-numbered page whose bit is clear and marks it used.
- R4: A transmit allocation with no free page makes the transmit result read 0x80 and leaves the request pending.
- R5: A transmit allocate command clears the allocation-done flag. The flag is set when that command or a later retry obtains a page, and the transmit result then shows the page number.
- R6: A release, from the host or from the receive path, clears the page's bit. A release of a page already free, or of a number not below NUM_PAGES, leaves the pool unchanged.
- R7: While a transmit allocation is pending, any valid release retries it in the same cycle. On success the result becomes the page number and the allocation-done flag rises.
- R8: A receive allocate request is answered one cycle later with a response-valid pulse and the page number, or 0x80 when the pool is full. In a cycle that also carries releases, the receive request sees the pool after those releases. It is served before a transmit allocation or a pending retry in the same cycle.
- R9: A pool reset command clears every bit, cancels a pending transmit allocation, sets the transmit result to 0x00 and clears the allocation-done flag. A receive request in the same cycle is answered with 0x80.
- R10: The free-page output always equals the number of pages whose bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Host command byte is present this cycle |
| cmd_byte | input | 8 | Host command, operation in bits [7:5] |
| pkt_num | input | 8 | Page number used by the host release command |
| rx_alloc_req | input | 1 | Receive path asks for a page |
| rx_rel_valid | input | 1 | Receive path gives back a page |
| rx_rel_page | input | 8 | Page number given back by the receive path |
| tx_result | output | 8 | Last transmit allocation result, 0x80 while pending |
| alloc_done | output | 1 | Transmit allocation-done flag |
| free_pages | output | $clog2(NUM_PAGES+1) | Count of free pages |
| rx_rsp_valid | output | 1 | Receive allocate response pulse |
| rx_rsp_page | output | 8 | Page granted to the receive path, or 0x80 |

## Verification
The bench drives the pool to full and then frees pages one at a time. It checks that a pending transmit allocation completes on the very release that frees a page. A design that waited for a new command, or retried without a release, would show a stale 0x80 or the wrong page. Same-cycle collisions are covered too: a receive request together with a release while a transmit allocation is pending must take the freed page and leave the transmit side at 0x80, and a receive request together with a transmit allocate must leave the receive side with the lower page. Releases of a page already free or of an out-of-range number must not move the free count. The last test issues a pool reset with an allocation pending, then a release, and checks that the cancelled request does not come back.

// File: rtl/pgalloc_pkg.sv
package pgalloc_pkg;

    // Result code meaning "no page obtained"; above any valid page number.
    localparam logic [7:0] NO_PAGE = 8'h80;

    // Host operation carried in the top three bits of the command byte.
    typedef enum logic [2:0] {
        OP_IDLE      = 3'd0,
        OP_TX_ALLOC  = 3'd1,
        OP_POOL_CLR  = 3'd2,
        OP_RELEASE   = 3'd5
    } host_op_e;

endpackage

// File: rtl/page_pick.sv
// Lowest-numbered clear bit finder.
module page_pick #(
    parameter int NUM_PAGES = 4,
    parameter int PAGE_W    = 2
) (
    input  logic [NUM_PAGES-1:0] used,
    output logic                 found,
    output logic [PAGE_W-1:0]    idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_PAGES - 1; i >= 0; i--) begin
            if (!used[i]) begin
                found = 1'b1;
                idx   = PAGE_W'(i);
            end
        end
    end
endmodule

// File: rtl/free_counter.sv
// Counts clear bits in the page map.
module free_counter #(
    parameter int NUM_PAGES = 4,
    parameter int CNT_W     = 3
) (
    input  logic [NUM_PAGES-1:0] used,
    output logic [CNT_W-1:0]     count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < NUM_PAGES; i++) begin
            count = count + CNT_W'(!used[i]);
        end
    end
endmodule

// File: rtl/page_allocator.sv
module page_allocator
    import pgalloc_pkg::*;
#(
    parameter int NUM_PAGES = 4,
    localparam int PAGE_W   = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
    localparam int CNT_W    = $clog2(NUM_PAGES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_byte,
    input  logic [7:0]       pkt_num,
    input  logic             rx_alloc_req,
    input  logic             rx_rel_valid,
    input  logic [7:0]       rx_rel_page,
    output logic [7:0]       tx_result,
    output logic             alloc_done,
    output logic [CNT_W-1:0] free_pages,
    output logic             rx_rsp_valid,
    output logic [7:0]       rx_rsp_page
);

    typedef struct packed {
        logic [NUM_PAGES-1:0] used;
        logic                 pend;
        logic                 done;
        logic [7:0]           res;
        logic                 rx_v;
        logic [7:0]           rx_pg;
    } state_t;

    state_t st_q, st_d;

    // Command decode
    logic [2:0] op;
    logic       op_alloc, op_clr, op_rel;
    logic       host_rel_ok, rx_rel_ok, any_rel;

    assign op          = cmd_byte[7:5];
    assign op_alloc    = cmd_valid && (op == OP_TX_ALLOC);
    assign op_clr      = cmd_valid && (op == OP_POOL_CLR);
    assign op_rel      = cmd_valid && (op == OP_RELEASE);
    assign host_rel_ok = op_rel && (pkt_num < 8'(NUM_PAGES));
    assign rx_rel_ok   = rx_rel_valid && (rx_rel_page < 8'(NUM_PAGES));
    assign any_rel     = host_rel_ok || rx_rel_ok;

    // Map after this cycle's releases, and after the receive grant
    logic [NUM_PAGES-1:0] map_rel, map_rx;
    logic                 rx_found, tx_found;
    logic [PAGE_W-1:0]    rx_idx, tx_idx;
    logic                 rx_take;

    always_comb begin
        map_rel = st_q.used;
        if (host_rel_ok) map_rel[pkt_num[PAGE_W-1:0]] = 1'b0;
        if (rx_rel_ok)   map_rel[rx_rel_page[PAGE_W-1:0]] = 1'b0;
    end

    page_pick #(.NUM_PAGES(NUM_PAGES), .PAGE_W(PAGE_W)) u_pick_rx (
        .used  (map_rel),
        .found (rx_found),
        .idx   (rx_idx)
    );

    assign rx_take = rx_alloc_req && rx_found && !op_clr;

    always_comb begin
        map_rx = map_rel;
        if (rx_take) map_rx[rx_idx] = 1'b1;
    end

    page_pick #(.NUM_PAGES(NUM_PAGES), .PAGE_W(PAGE_W)) u_pick_tx (
        .used  (map_rx),
        .found (tx_found),
        .idx   (tx_idx)
    );

    // Next-state logic
    always_comb begin
        logic tx_try;
        st_d       = st_q;
        st_d.used  = map_rx;
        st_d.rx_v  = rx_alloc_req;
        st_d.rx_pg = rx_take ? 8'(rx_idx) : NO_PAGE;

        tx_try = op_alloc || (st_q.pend && any_rel);
        if (op_alloc) st_d.done = 1'b0;
        if (tx_try) begin
            if (tx_found) begin
                st_d.used[tx_idx] = 1'b1;
                st_d.res          = 8'(tx_idx);
                st_d.pend         = 1'b0;
                st_d.done         = 1'b1;
            end else begin
                st_d.res  = NO_PAGE;
                st_d.pend = 1'b1;
            end
        end

        if (op_clr) begin
            st_d.used = '0;
            st_d.pend = 1'b0;
            st_d.done = 1'b0;
            st_d.res  = 8'h00;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    free_counter #(.NUM_PAGES(NUM_PAGES), .CNT_W(CNT_W)) u_free (
        .used  (st_q.used),
        .count (free_pages)
    );

    assign tx_result    = st_q.res;
    assign alloc_done   = st_q.done;
    assign rx_rsp_valid = st_q.rx_v;
    assign rx_rsp_page  = st_q.rx_pg;

    // R4: a pending transmit request always shows the failure code
    a_r4_pend_code: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend |-> (tx_result == NO_PAGE));

    // R5: the done flag only rises together with a real page number
    a_r5_done_page: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alloc_done) |-> (tx_result < 8'(NUM_PAGES)));

    // R7: a release while pending, with no competing receive request, completes it
    a_r7_retry: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && any_rel && !rx_alloc_req && !op_clr) |=> (!st_q.pend && alloc_done));

    // R8: a receive response follows a receive request
    a_r8_rsp_follow: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rsp_valid |-> $past(rx_alloc_req));

    // R9: pool reset empties the pool and cancels any pending request
    a_r9_pool_clr: assert property (@(posedge clk) disable iff (!rst_n)
        op_clr |=> (free_pages == CNT_W'(NUM_PAGES) && !st_q.pend));

    // R10: free count never exceeds the pool
    a_r10_free_bound: assert property (@(posedge clk) disable iff (!rst_n)
        free_pages <= CNT_W'(NUM_PAGES));

endmodule

// File: tb/sim_page_allocator.sv
module sim_page_allocator;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int CW = $clog2(NP + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [7:0]    cmd_byte = 8'h00;
    logic [7:0]    pkt_num = 8'h00;
    logic          rx_alloc_req = 1'b0;
    logic          rx_rel_valid = 1'b0;
    logic [7:0]    rx_rel_page = 8'h00;
    logic [7:0]    tx_result;
    logic          alloc_done;
    logic [CW-1:0] free_pages;
    logic          rx_rsp_valid;
    logic [7:0]    rx_rsp_page;

    always #(CLK_PERIOD/2) clk = ~clk;

    page_allocator #(.NUM_PAGES(NP)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .pkt_num(pkt_num),
        .rx_alloc_req(rx_alloc_req), .rx_rel_valid(rx_rel_valid), .rx_rel_page(rx_rel_page),
        .tx_result(tx_result), .alloc_done(alloc_done), .free_pages(free_pages),
        .rx_rsp_valid(rx_rsp_valid), .rx_rsp_page(rx_rsp_page)
    );

    typedef struct {
        string req;
        int    field;   // 0 result, 1 done, 2 free, 3 rx valid, 4 rx page
        int    value;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done_run = 1'b0;

    function automatic int actual(int f);
        case (f)
            0: return int'(tx_result);
            1: return int'(alloc_done);
            2: return int'(free_pages);
            3: return int'(rx_rsp_valid);
            default: return int'(rx_rsp_page);
        endcase
    endfunction

    // Monitor: compares after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            while (exp_q.size() > 0) begin
                exp_t e;
                int   a;
                e = exp_q.pop_front();
                a = actual(e.field);
                n_cmp++;
                if (a !== e.value) begin
                    n_bad++;
                    $display("FAIL %s field %0d: actual 0x%0h expected 0x%0h", e.req, e.field, a, e.value);
                end
            end
        end
    end

    task automatic op(input bit cv, input logic [7:0] cb, input logic [7:0] pn,
                      input bit ra, input bit rr, input logic [7:0] rp);
        @(negedge clk);
        cmd_valid    = cv;
        cmd_byte     = cb;
        pkt_num      = pn;
        rx_alloc_req = ra;
        rx_rel_valid = rr;
        rx_rel_page  = rp;
    endtask

    task automatic ex(input string r, input int f, input int v);
        exp_t e;
        e.req = r; e.field = f; e.value = v;
        exp_q.push_back(e);
    endtask

    task automatic tick();
        @(posedge clk);
    endtask

    task automatic host(input logic [7:0] cb, input logic [7:0] pn);
        op(1'b1, cb, pn, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic rxop(input bit ra, input bit rr, input logic [7:0] rp);
        op(1'b0, 8'h00, 8'h00, ra, rr, rp);
    endtask

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done_run) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rxop(0, 0, 0);
        ex("R1", 0, 0); ex("R1", 1, 0); ex("R1", 2, 4); ex("R1", 3, 0); tick();
        // R2 R3: allocate, lowest page first
        host(8'h20, 0); ex("R3", 0, 0); ex("R5", 1, 1); ex("R10", 2, 3); tick();
        // R2: low bits ignored
        host(8'h3F, 0); ex("R2", 0, 1); ex("R10", 2, 2); tick();
        // R8: receive gets page 2
        rxop(1, 0, 0); ex("R8", 3, 1); ex("R8", 4, 2); ex("R10", 2, 1); tick();
        // R2: unused code 3 has no effect
        host(8'h60, 0); ex("R2", 0, 1); ex("R2", 2, 1); ex("R2", 1, 1); ex("R8", 3, 0); tick();
        host(8'h20, 0); ex("R3", 0, 3); ex("R10", 2, 0); tick();
        // R4 R5: full pool
        host(8'h20, 0); ex("R4", 0, 8'h80); ex("R5", 1, 0); ex("R4", 2, 0); tick();
        // R8: receive when full
        rxop(1, 0, 0); ex("R8", 3, 1); ex("R8", 4, 8'h80); ex("R4", 0, 8'h80); tick();
        // R7: release page 1 retries pending
        host(8'hA0, 1); ex("R7", 0, 1); ex("R7", 1, 1); ex("R7", 2, 0); tick();
        // R6: out-of-range release ignored
        host(8'hA0, 7); ex("R6", 2, 0); ex("R6", 0, 1); tick();
        // R6: receive-path release of page 2
        rxop(0, 1, 2); ex("R6", 2, 1); ex("R6", 0, 1); tick();
        // R6: second release of a free page
        rxop(0, 1, 2); ex("R6", 2, 1); tick();
        host(8'h20, 0); ex("R3", 0, 2); ex("R5", 1, 1); ex("R10", 2, 0); tick();
        host(8'h20, 0); ex("R4", 0, 8'h80); ex("R5", 1, 0); tick();
        // R8: receive beats pending retry on same-cycle release
        rxop(1, 1, 0); ex("R8", 4, 0); ex("R8", 0, 8'h80); ex("R8", 1, 0); ex("R8", 2, 0); tick();
        // R7: host release page 3 completes pending
        host(8'hA0, 3); ex("R7", 0, 3); ex("R7", 1, 1); ex("R7", 2, 0); tick();
        rxop(0, 1, 0); ex("R6", 2, 1); tick();
        rxop(0, 1, 1); ex("R6", 2, 2); ex("R7", 0, 3); tick();
        // R8: receive and transmit allocate together
        op(1'b1, 8'h20, 8'h00, 1'b1, 1'b0, 8'h00);
        ex("R8", 4, 0); ex("R8", 0, 1); ex("R8", 1, 1); ex("R10", 2, 0); tick();
        host(8'h20, 0); ex("R4", 0, 8'h80); tick();
        // R9: pool reset with pending request
        host(8'h40, 0); ex("R9", 2, 4); ex("R9", 0, 0); ex("R9", 1, 0); tick();
        rxop(1, 0, 0); ex("R9", 4, 0); ex("R10", 2, 3); tick();
        // R9: cancelled request does not return on release
        rxop(0, 1, 0); ex("R9", 2, 4); ex("R9", 0, 0); ex("R9", 1, 0); tick();
        rxop(0, 0, 0);
        repeat (2) @(posedge clk);
        #(CLK_PERIOD/2);
        done_run = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule